// File: doc/BRIEF.md
# Sampled-Edge Timer/Event Counter

This block is a 16-bit up-counter with two sources of increment, chosen by a single mode input. In timer mode it advances once per machine cycle. In counter mode it counts falling edges on an external pin. The pin is not treated as a clock. It is synchronised and then sampled once per machine cycle at a fixed late phase. An edge is recognised when one sample is high and the next one is low. The count then moves at the early phase of the following machine cycle.

The machine cycle is twelve clocks long and is defined by two one-clock strobes from the surrounding core: an early update strobe and a late sample strobe. Software sees the count as a low byte and a high byte and can load either byte.

Two sticky flags feed one interrupt request:
- an overflow flag, set when the count wraps;
- an external-event flag, set by a pulse from neighbouring capture logic.

Hardware never clears these flags. Software clears them, or sets them, through a flag write.

Top module: `tc_timer_counter`

## Requirements
- R1: While reset is high, and right after it falls, the count is 0x0000, both flags are 0 and `irq` is 0.
- R2: With `cnt_mode`=0 (timer), the count rises by exactly one on each clock where `stb_update` is high and holds on every other clock.
- R3: With `cnt_mode`=1 (counter), a falling edge is recognised when the pin sample taken at one `stb_sample` is high and the sample at the next `stb_sample` is low. The count rises by one at the next `stb_update`. Steady levels and rising edges add nothing.
- R4: A pin level that lies entirely between two `stb_sample` strobes is not seen. A pin that alternates level every machine cycle yields one count per two machine cycles.
- R5: On an increment from 0xFFFF the count becomes 0x0000, and `ovf_flag` (flag bit 0) is set at that same clock edge.
- R6: A one-clock pulse on `evt_in` sets `evt_flag` (flag bit 1) at the next clock edge.
- R7: The flags stay set until software writes them (`wr_sel`=2, data bit 0 = overflow, bit 1 = event). When a hardware set and a software write to the same flag fall on the same clock, the hardware set wins.
- R8: `irq` is high whenever at least one flag is set, including a flag set by software.
- R9: A write with `wr_sel`=0 loads the low byte and a write with `wr_sel`=1 loads the high byte. When a byte write falls on the same clock as an increment, the write wins and that increment is dropped for the whole 16-bit count.
- R10: In counter mode an update strobe with no recognised edge leaves the count unchanged. In timer mode the pin has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_sample | input | 1 | Late-phase strobe, one clock per machine cycle; the pin is sampled here |
| stb_update | input | 1 | Early-phase strobe, one clock per machine cycle; increments happen here |
| ext_pin | input | 1 | External count pin (asynchronous) |
| evt_in | input | 1 | Pulse that sets the external-event flag |
| cnt_mode | input | 1 | 0 = timer, 1 = counter |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | 0 = low byte, 1 = high byte, 2 = flags, 3 = none |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 8 | Low byte of the count |
| cnt_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Overflow flag |
| evt_flag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |

## Verification
The following are checked on every cycle:
- the timer step on each update strobe;
- that the count holds between strobes;
- that a wrap from 0xFFFF coincides with the overflow flag being set;
- that the flags stay set until software writes them;
- that the event pulse sets its flag;
- that a low-byte write lands.

The counter-mode behaviour can only be shown by the bench's scenarios. This covers the two-cycle latency from edge to count, the rejection of rising edges and of glitches between samples, and the one-count-per-two-cycles ceiling. The scenarios also show that a write wins over an increment on the same clock, and that a hardware flag set wins over a software clear on the same clock.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int BYTE_W_DEF = 8;

    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } tc_mode_e;

    typedef enum logic [1:0] {
        SEL_LO    = 2'd0,
        SEL_HI    = 2'd1,
        SEL_FLAGS = 2'd2,
        SEL_NONE  = 2'd3
    } tc_sel_e;

    // bit 1: external event, bit 0: overflow
    typedef struct packed {
        logic evt;
        logic ovf;
    } tc_flags_t;

    // a falling edge: previous machine-cycle sample high, current one low
    function automatic logic fall_seen(input logic last_smp, input logic new_smp);
        return last_smp & ~new_smp;
    endfunction

endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                if (i == 0) begin : g_first
                    always_ff @(posedge clk) begin
                        if (rst) sh[0] <= 1'b0;
                        else     sh[0] <= d;
                    end
                end else begin : g_next
                    always_ff @(posedge clk) begin
                        if (rst) sh[i] <= 1'b0;
                        else     sh[i] <= sh[i-1];
                    end
                end
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tc_edge_sampler.sv
module tc_edge_sampler (
    input  logic clk,
    input  logic rst,
    input  logic stb_sample,
    input  logic stb_update,
    input  logic pin_s,
    input  logic arm,
    output logic edge_tick
);
    import tc_pkg::*;

    logic last_q;
    logic pend_q;
    logic fall_now;

    assign fall_now = stb_sample & arm & fall_seen(last_q, pin_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (stb_sample)
                last_q <= pin_s;
            if (fall_now)
                pend_q <= 1'b1;
            else if (stb_update)
                pend_q <= 1'b0;
        end
    end

    // the recognised edge is spent at the next early-phase strobe
    assign edge_tick = stb_update & pend_q & arm;
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inc,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [2*BYTE_W-1:0]   count,
    output logic                  wrap
);
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int LANES  = CNT_W / BYTE_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic [LANES-1:0] lane_wr;
    logic             any_wr;
    logic             step;

    assign sum     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign lane_wr = {wr_hi, wr_lo};
    assign any_wr  = |lane_wr;
    assign step    = inc & ~any_wr;

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q[b*BYTE_W +: BYTE_W] <= '0;
                else if (lane_wr[b])
                    cnt_q[b*BYTE_W +: BYTE_W] <= wr_data;
                else if (step)
                    cnt_q[b*BYTE_W +: BYTE_W] <= sum[b*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    assign count = cnt_q;
    assign wrap  = step & sum[CNT_W];
endmodule

// File: rtl/tc_flag_unit.sv
module tc_flag_unit (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_ovf,
    input  logic              set_evt,
    input  logic              wr_flags,
    input  tc_pkg::tc_flags_t wr_bits,
    output tc_pkg::tc_flags_t flags
);
    tc_pkg::tc_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            if (wr_flags)
                flags_q <= wr_bits;
            // hardware sets come last so they win over a same-clock clear
            if (set_ovf)
                flags_q.ovf <= 1'b1;
            if (set_evt)
                flags_q.evt <= 1'b1;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/tc_timer_counter.sv
module tc_timer_counter #(
    parameter int BYTE_W      = tc_pkg::BYTE_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_sample,
    input  logic              stb_update,
    input  logic              ext_pin,
    input  logic              evt_in,
    input  logic              cnt_mode,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf_flag,
    output logic              evt_flag,
    output logic              irq
);
    import tc_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    tc_mode_e          mode;
    tc_sel_e           sel;
    logic              pin_s;
    logic              edge_tick;
    logic              inc;
    logic              wrap;
    logic [CNT_W-1:0]  count;
    tc_flags_t         flags;
    tc_flags_t         wr_bits;

    assign mode    = tc_mode_e'(cnt_mode);
    assign sel     = tc_sel_e'(wr_sel);
    assign wr_bits = tc_flags_t'(wr_data[1:0]);

    tc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_pin),
        .q   (pin_s)
    );

    tc_edge_sampler u_smp (
        .clk        (clk),
        .rst        (rst),
        .stb_sample (stb_sample),
        .stb_update (stb_update),
        .pin_s      (pin_s),
        .arm        (mode == MODE_COUNTER),
        .edge_tick  (edge_tick)
    );

    assign inc = (mode == MODE_TIMER) ? stb_update : edge_tick;

    tc_count_core #(.BYTE_W(BYTE_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .wr_lo   (wr_en && sel == SEL_LO),
        .wr_hi   (wr_en && sel == SEL_HI),
        .wr_data (wr_data),
        .count   (count),
        .wrap    (wrap)
    );

    tc_flag_unit u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_ovf  (wrap),
        .set_evt  (evt_in),
        .wr_flags (wr_en && sel == SEL_FLAGS),
        .wr_bits  (wr_bits),
        .flags    (flags)
    );

    assign cnt_lo   = count[BYTE_W-1:0];
    assign cnt_hi   = count[CNT_W-1:BYTE_W];
    assign ovf_flag = flags.ovf;
    assign evt_flag = flags.evt;
    assign irq      = flags.ovf | flags.evt;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              stb_update,
    input logic              evt_in,
    input logic              cnt_mode,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] cnt_lo,
    input logic [BYTE_W-1:0] cnt_hi,
    input logic              ovf_flag,
    input logic              evt_flag
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] count_w;
    logic             byte_wr;
    logic             flag_wr;

    assign count_w = {cnt_hi, cnt_lo};
    assign byte_wr = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1);
    assign flag_wr = wr_en && (wr_sel == 2'd2);

    a_r2_timer_step: assert property (@(posedge clk) disable iff (rst)
        (!cnt_mode && stb_update && !byte_wr) |=> count_w == CNT_W'($past(count_w) + 1'b1));

    a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!stb_update && !byte_wr) |=> $stable(count_w));

    a_r5_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (!cnt_mode && stb_update && !byte_wr && count_w == {CNT_W{1'b1}})
        |=> (count_w == '0 && ovf_flag));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_wr) |=> ovf_flag);

    a_r7_evt_sticky: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !flag_wr) |=> evt_flag);

    a_r6_evt_sets: assert property (@(posedge clk) disable iff (rst)
        evt_in |=> evt_flag);

    a_r9_lo_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> cnt_lo == $past(wr_data));
endmodule

bind tc_timer_counter tc_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stb_update (stb_update),
    .evt_in     (evt_in),
    .cnt_mode   (cnt_mode),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .ovf_flag   (ovf_flag),
    .evt_flag   (evt_flag)
);

// File: tb/tc_timer_counter_test.sv
`timescale 1ns/1ps
module tc_timer_counter_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       stb_sample, stb_update;
    logic       ext_pin, evt_in, cnt_mode, wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag, evt_flag, irq;

    always #2.5 clk = ~clk;

    tc_timer_counter uut (
        .clk(clk), .rst(rst), .stb_sample(stb_sample), .stb_update(stb_update),
        .ext_pin(ext_pin), .evt_in(evt_in), .cnt_mode(cnt_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ovf_flag(ovf_flag), .evt_flag(evt_flag), .irq(irq)
    );

    typedef struct {
        string       tag;
        int          kind;   // 0: count, 1: {irq, evt, ovf}
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk  = 0;
    int    n_fail = 0;
    int    ph     = 0;
    bit    done   = 0;

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = (it.kind == 0) ? {cnt_hi, cnt_lo} : {13'd0, irq, evt_flag, ovf_flag};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        stb_update = (ph == 1);
        stb_sample = (ph == 9);
        @(posedge clk);
        @(negedge clk);
        ph = (ph + 1) % 12;
    endtask

    task automatic mcyc(input int n);
        repeat (n * 12) tick();
    endtask

    task automatic write(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic exp_count(input string tag, input logic [15:0] v);
        q.push_back('{tag: tag, kind: 0, exp: v});
        -> chk_ev;
    endtask

    task automatic exp_flags(input string tag, input logic [2:0] v);
        q.push_back('{tag: tag, kind: 1, exp: {13'd0, v}});
        -> chk_ev;
    endtask

    initial begin
        rst = 1'b1; stb_sample = 1'b0; stb_update = 1'b0; ext_pin = 1'b0;
        evt_in = 1'b0; cnt_mode = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00;
        @(negedge clk);
        repeat (12) tick();
        exp_count("R1 count in reset", 16'h0000);
        exp_flags("R1 flags in reset", 3'b000);
        rst = 1'b0;
        tick(); tick(); repeat (10) tick();         // ph back to 0, one update seen
        exp_count("R2 one step after reset", 16'h0001);

        // timer mode stepping
        mcyc(4);
        exp_count("R2 five machine cycles", 16'h0005);
        tick();                                     // ph0: no strobe
        exp_count("R2 hold without strobe", 16'h0005);
        tick();                                     // ph1
        exp_count("R2 step on strobe", 16'h0006);
        repeat (10) tick();

        // byte writes and wrap
        write(2'd0, 8'hFE);                         // ph0
        write(2'd1, 8'hFF);                         // ph1, collides with update
        exp_count("R9 write wins over increment", 16'hFFFE);
        repeat (10) tick(); tick(); tick();
        exp_count("R2 reach FFFF", 16'hFFFF);
        exp_flags("R5 no flag before wrap", 3'b000);
        repeat (10) tick(); tick(); tick();
        exp_count("R5 wrap to zero", 16'h0000);
        exp_flags("R5 ovf set at wrap, R8 irq", 3'b101);
        repeat (10) tick();
        mcyc(1);
        exp_flags("R7 ovf stays set", 3'b101);
        write(2'd2, 8'h00);                         // ph0
        exp_flags("R7 software clear", 3'b000);
        evt_in = 1'b1;
        write(2'd2, 8'h00);                         // ph1, evt set vs clear
        evt_in = 1'b0;
        exp_flags("R6 R7 event set beats clear", 3'b110);
        write(2'd2, 8'h00);
        exp_flags("R7 clear event", 3'b000);
        write(2'd2, 8'h01);
        exp_flags("R8 irq from software-set ovf", 3'b101);
        write(2'd2, 8'h00);
        repeat (7) tick();
        exp_count("R2 count after flag traffic", 16'h0002);

        // counter mode
        cnt_mode = 1'b1;
        mcyc(2);
        exp_count("R10 no edge no count", 16'h0002);
        ext_pin = 1'b1; mcyc(1);
        ext_pin = 1'b0; mcyc(1);
        exp_count("R3 edge not yet visible", 16'h0002);
        tick(); tick();
        exp_count("R3 count after next update", 16'h0003);
        repeat (10) tick();
        mcyc(2);
        exp_count("R3 steady low adds nothing", 16'h0003);
        ext_pin = 1'b1; mcyc(2);
        exp_count("R3 rising edge adds nothing", 16'h0003);
        tick(); tick();
        ext_pin = 1'b0; repeat (5) tick();
        ext_pin = 1'b1; repeat (5) tick();
        mcyc(1);
        exp_count("R4 glitch between samples ignored", 16'h0003);
        for (int k = 0; k < 4; k++) begin
            ext_pin = 1'b0; mcyc(1);
            ext_pin = 1'b1; mcyc(1);
        end
        exp_count("R4 max rate one per two cycles", 16'h0007);

        // timer mode ignores the pin
        cnt_mode = 1'b0;
        for (int t = 0; t < 36; t++) begin
            if (t % 4 == 0) ext_pin = ~ext_pin;
            tick();
        end
        exp_count("R10 pin ignored in timer mode", 16'h000A);

        #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..R10 run actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule